// File: doc/BRIEF.md
# Serial DAC Input Register

This block receives words for a 14-bit voltage-output DAC over a three-wire serial link made of an active-low select, a serial clock and a data line. All three wires, and an optional active-low load strobe, are brought into the system clock domain through synchronizers. Inside that domain the block detects the edges of the serial clock, the select and the load strobe.

While select is low, every rising edge of the serial clock shifts the data line into a shift register, most significant bit first. The register keeps only the latest 14 bits. A frame may therefore be longer than the word, and the bits that arrive first are then dropped. A frame that ends with fewer than 14 rising edges is thrown away.

A static mode input chooses how the DAC code register is written. In automatic mode it loads the completed word when select rises. In strobe mode the rise of select only fills a holding register, and a falling edge on the load strobe copies the holding register into the code register. Every write of the code register comes with a one-cycle update pulse.

Top module: `dacin_rx`

## Requirements
- R1: During synchronous reset and after it, the DAC code is 0 and the update pulse is low until a valid transfer occurs.
- R2: In automatic mode (mode_auto=1), after a frame of exactly 14 rising serial clock edges, the DAC code equals the 14 sampled bits with the first sampled bit as bit 13. This happens after select rises, with exactly one update pulse.
- R3: A frame with more than 14 rising edges loads only the last 14 sampled bits. The earlier bits have no effect.
- R4: A frame with 0 to 13 rising edges leaves the DAC code unchanged and produces no update pulse.
- R5: In strobe mode (mode_auto=0), the rise of select at the end of a full frame leaves the DAC code unchanged and produces no update pulse.
- R6: In strobe mode, a falling edge of load_n copies the word of the last full frame into the DAC code, with exactly one update pulse.
- R7: In strobe mode, a falling edge of load_n while a frame is still being shifted loads the previously held word, not the partial word.
- R8: In automatic mode, load_n edges leave the DAC code unchanged and produce no update pulse.
- R9: The update pulse lasts one clock cycle, and the DAC code changes only in a cycle where the update pulse is high.
- R10: In strobe mode, a short frame leaves the held word unchanged, so a later load strobe still delivers the word of the last full frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| mode_auto | input | 1 | 1: update on select rise, 0: update on load strobe; held static |
| cs_n | input | 1 | Serial select, active low, asynchronous |
| sclk | input | 1 | Serial clock, data sampled on its rising edge, asynchronous |
| sdi | input | 1 | Serial data, MSB first, asynchronous |
| load_n | input | 1 | Load strobe, acts on its falling edge, asynchronous |
| dac_code | output | 14 | DAC code register |
| dac_upd | output | 1 | One-cycle pulse when dac_code is written |

## Verification
The bound checker checks on every cycle how the internal events map onto updates. A full frame in automatic mode loads the shifted word. A load edge in strobe mode loads the held word. A short frame, a select rise in strobe mode and a load edge in automatic mode raise no update. The code never moves without a pulse, and each pulse lasts one cycle. Only the bench scenarios can show bit order, that frames longer than 14 bits keep their last 14, and what happens across frame sequences. Those sequences are a load strobe in the middle of a frame and a short frame that must leave the held word intact. Both depend on serial timing that no single-cycle property sees.

// File: rtl/dacin_pkg.sv
package dacin_pkg;
  localparam int CODE_W = 14;

  // shift a new serial bit in at the LSB, oldest bit falls off the MSB
  function automatic logic [CODE_W-1:0] shift_in(input logic [CODE_W-1:0] cur, input logic b);
    return {cur[CODE_W-2:0], b};
  endfunction

  // a frame is usable once it has at least one full word of clock edges
  function automatic logic frame_complete(input int unsigned edges);
    return edges >= CODE_W;
  endfunction
endpackage

// File: rtl/dacin_sync.sv
module dacin_sync #(
  parameter int N      = 4,
  parameter int STAGES = 2,
  parameter logic [N-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] din,
  output logic [N-1:0] dout,
  output logic [N-1:0] dout_d
);
  for (genvar g = 0; g < N; g++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk) begin
      if (rst) chain <= {STAGES{RST_VAL[g]}};
      else     chain <= {chain[STAGES-2:0], din[g]};
    end
    always_ff @(posedge clk) begin
      if (rst) dout_d[g] <= RST_VAL[g];
      else     dout_d[g] <= chain[STAGES-1];
    end
    assign dout[g] = chain[STAGES-1];
  end
endmodule

// File: rtl/dacin_shift.sv
module dacin_shift
  import dacin_pkg::*;
#(
  parameter int W     = CODE_W,
  localparam int CNT_W = $clog2(W + 1)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         cs_lo,
  input  logic         sclk_rise,
  input  logic         sdi_s,
  output logic [W-1:0] word,
  output logic         frame_full
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      word <= '0;
      cnt  <= '0;
    end else if (!cs_lo) begin
      cnt <= '0;
    end else if (sclk_rise) begin
      word <= shift_in(word, sdi_s);
      if (!frame_complete(int'(cnt))) cnt <= cnt + 1'b1;
    end
  end

  assign frame_full = frame_complete(int'(cnt));
endmodule

// File: rtl/dacin_update.sv
module dacin_update #(
  parameter int W = 14
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         mode_auto,
  input  logic         cs_rise,
  input  logic         frame_full,
  input  logic         load_fall,
  input  logic [W-1:0] word,
  output logic [W-1:0] hold,
  output logic [W-1:0] dac_code,
  output logic         dac_upd
);
  logic take;
  assign take = cs_rise & frame_full;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold     <= '0;
      dac_code <= '0;
      dac_upd  <= 1'b0;
    end else begin
      dac_upd <= 1'b0;
      if (mode_auto) begin
        if (take) begin
          dac_code <= word;
          dac_upd  <= 1'b1;
        end
      end else begin
        if (take) hold <= word;
        if (load_fall) begin
          dac_code <= hold;
          dac_upd  <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/dacin_rx.sv
module dacin_rx
  import dacin_pkg::*;
#(
  parameter int W           = CODE_W,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         mode_auto,
  input  logic         cs_n,
  input  logic         sclk,
  input  logic         sdi,
  input  logic         load_n,
  output logic [W-1:0] dac_code,
  output logic         dac_upd
);
  localparam int NSIG = 4;
  localparam int I_CS = 0, I_CK = 1, I_DI = 2, I_LD = 3;

  logic [NSIG-1:0] s_now, s_prev;
  logic            cs_rise, sclk_rise, load_fall, frame_full;
  logic [W-1:0]    word, hold;

  dacin_sync #(.N(NSIG), .STAGES(SYNC_STAGES), .RST_VAL(4'b1001)) u_sync (
    .clk(clk), .rst(rst), .din({load_n, sdi, sclk, cs_n}),
    .dout(s_now), .dout_d(s_prev)
  );

  assign cs_rise   = s_now[I_CS] & ~s_prev[I_CS];
  assign sclk_rise = s_now[I_CK] & ~s_prev[I_CK];
  assign load_fall = ~s_now[I_LD] & s_prev[I_LD];

  dacin_shift #(.W(W)) u_shift (
    .clk(clk), .rst(rst), .cs_lo(~s_now[I_CS]), .sclk_rise(sclk_rise),
    .sdi_s(s_now[I_DI]), .word(word), .frame_full(frame_full)
  );

  dacin_update #(.W(W)) u_upd (
    .clk(clk), .rst(rst), .mode_auto(mode_auto), .cs_rise(cs_rise),
    .frame_full(frame_full), .load_fall(load_fall), .word(word),
    .hold(hold), .dac_code(dac_code), .dac_upd(dac_upd)
  );
endmodule

// File: rtl/dacin_rx_chk.sv
module dacin_rx_chk #(
  parameter int W = 14
) (
  input logic         clk,
  input logic         rst,
  input logic         mode_auto,
  input logic         cs_rise,
  input logic         load_fall,
  input logic         frame_full,
  input logic [W-1:0] word,
  input logic [W-1:0] hold,
  input logic [W-1:0] dac_code,
  input logic         dac_upd
);
  AST_AUTO_LOAD: assert property (@(posedge clk) disable iff (rst)
    cs_rise && frame_full && mode_auto |=> dac_upd && dac_code == $past(word)); // R2
  AST_SHORT_DROP: assert property (@(posedge clk) disable iff (rst)
    cs_rise && !frame_full && (mode_auto || !load_fall) |=> !dac_upd); // R4
  AST_STROBE_NO_AUTO: assert property (@(posedge clk) disable iff (rst)
    cs_rise && !mode_auto && !load_fall |=> !dac_upd); // R5
  AST_STROBE_LOAD: assert property (@(posedge clk) disable iff (rst)
    load_fall && !mode_auto |=> dac_upd && dac_code == $past(hold)); // R6
  AST_AUTO_IGNORE_LOAD: assert property (@(posedge clk) disable iff (rst)
    load_fall && mode_auto && !cs_rise |=> !dac_upd); // R8
  AST_UPD_SINGLE: assert property (@(posedge clk) disable iff (rst)
    dac_upd |=> !dac_upd); // R9
  AST_CODE_WITH_UPD: assert property (@(posedge clk) disable iff (rst)
    !$stable(dac_code) |-> dac_upd); // R9
endmodule

bind dacin_rx dacin_rx_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .mode_auto(mode_auto), .cs_rise(cs_rise),
  .load_fall(load_fall), .frame_full(frame_full), .word(word), .hold(hold),
  .dac_code(dac_code), .dac_upd(dac_upd)
);

// File: tb/sim_dacin_rx.sv
module sim_dacin_rx;
  localparam int W = 14;
  localparam int HALF = 4;

  logic clk = 0, rst = 1, mode_auto = 1, cs_n = 1, sclk = 0, sdi = 0, load_n = 1;
  logic [W-1:0] dac_code;
  logic dac_upd;
  int errors = 0, checks = 0, upd_cnt = 0, upd_mark = 0;
  logic [W-1:0] exp_dac = '0, exp_hold = '0;

  always #2.5 clk = ~clk;

  dacin_rx u0 (.clk(clk), .rst(rst), .mode_auto(mode_auto), .cs_n(cs_n), .sclk(sclk),
               .sdi(sdi), .load_n(load_n), .dac_code(dac_code), .dac_upd(dac_upd));

  always @(negedge clk) if (!rst && dac_upd) upd_cnt++;

  task automatic wait_clk(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [W-1:0] exp_code, input int exp_upd);
    checks++;
    if (dac_code !== exp_code || (upd_cnt - upd_mark) != exp_upd) begin
      errors++;
      $display("FAIL %s: code=%h upd=%0d expected code=%h upd=%0d",
               req, dac_code, upd_cnt - upd_mark, exp_code, exp_upd);
    end
    upd_mark = upd_cnt;
  endtask

  task automatic pulse_load();
    load_n = 0; wait_clk(HALF);
    load_n = 1; wait_clk(HALF);
  endtask

  // sends n bits of v, bit n-1 first; optional load pulse after 'split' bits
  task automatic frame(input int n, input logic [31:0] v, input int split);
    @(negedge clk); cs_n = 0; wait_clk(HALF);
    for (int i = n - 1; i >= 0; i--) begin
      if (n - 1 - i == split) pulse_load();
      sclk = 0; sdi = v[i]; wait_clk(HALF);
      sclk = 1; wait_clk(HALF);
    end
    sclk = 0; wait_clk(HALF);
    cs_n = 1; wait_clk(10);
  endtask

  initial begin : watchdog
    wait_clk(190000);
    errors++; checks++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : stim
    logic [W-1:0] w;
    wait_clk(5);
    check("R1 in reset", '0, 0);
    rst = 0; wait_clk(6);
    check("R1 after reset", '0, 0);

    // R2: walking ones and zeros, exact 14-bit frames
    for (int b = 0; b < W; b++) begin
      w = W'(1) << b;
      frame(W, 32'(w), -1); exp_dac = w; check("R2 walking one", exp_dac, 1);
      w = ~w;
      frame(W, 32'(w), -1); exp_dac = w; check("R2 walking zero", exp_dac, 1);
    end

    // R3: long frames, leading bits arbitrary
    for (int k = 0; k < 24; k++) begin
      logic [31:0] v;
      v = 32'(k) * 32'd2654435761 + 32'd12345;
      frame(W + 1 + (k % 6), v, -1);
      exp_dac = v[W-1:0]; check("R3 long frame", exp_dac, 1);
    end

    // R4: short frames of every length below a word
    for (int n = 0; n < W; n++) begin
      frame(n, ~32'(exp_dac), -1); check("R4 short frame", exp_dac, 0);
    end

    // R8: load strobe ignored in auto mode
    pulse_load(); pulse_load(); wait_clk(6);
    check("R8 load in auto", exp_dac, 0);

    // strobe mode
    mode_auto = 0; wait_clk(4);
    for (int k = 0; k < 8; k++) begin
      w = W'(k * 3109 + 77);
      frame(W + (k % 3), 32'(w), -1); exp_hold = w;
      check("R5 no update on select", exp_dac, 0);
      pulse_load(); wait_clk(4); exp_dac = exp_hold;
      check("R6 load strobe", exp_dac, 1);
    end

    // R7: load in the middle of a frame delivers previous held word
    frame(W, 32'h1A5C, -1); exp_hold = W'(32'h1A5C);
    check("R5 frame held", exp_dac, 0);
    frame(W, 32'h0F33, 7); exp_dac = W'(32'h1A5C);
    check("R7 mid-frame load", exp_dac, 1);
    exp_hold = W'(32'h0F33);
    pulse_load(); wait_clk(4); exp_dac = exp_hold;
    check("R7 next load", exp_dac, 1);

    // R10: short frame keeps held word
    frame(W, 32'h2B71, -1); exp_hold = W'(32'h2B71);
    frame(9, 32'h1FF, -1);
    frame(13, 32'h0AAA, -1);
    check("R10 short frames no update", exp_dac, 0);
    pulse_load(); wait_clk(4); exp_dac = exp_hold;
    check("R10 held word survives", exp_dac, 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule